// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block keeps the burst settings of a synchronous DRAM mode register and turns a single read or write start into a stream of column addresses, one per clock. A mode-set strobe loads three fields from a 7-bit opcode: the burst length, the beat order, and the CAS latency. The CAS latency is only stored and presented for the data-path logic downstream.

A start strobe supplies the first column of a burst. From the next cycle on, the block presents one address per clock, together with a valid flag and a last-beat flag. Bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that many columns, in either sequential or interleaved order. A full-page burst walks the 1024-column row and wraps until it is stopped or replaced. A stop strobe ends a burst of any length, and a new start replaces a running burst at once.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid and col_last are 0, cas_lat is 0, and the stored mode is a 1-beat sequential burst.
- R2: When mrs_stb is high at a clock edge, mrs_op is stored with length code in bits 2:0 (000 = 1 beat, 001 = 2, 010 = 4, 011 = 8, 111 = full page), order in bit 3 (0 = sequential, 1 = interleaved) and CAS latency in bits 6:4; cas_lat shows bits 6:4 from the next cycle.
- R3: In the cycle after start_stb is sampled, col_valid is 1 and col_addr equals start_col; one further beat follows on each clock.
- R4: In sequential order with burst length BL, beat n keeps the column bits above log2(BL) at their start value, and its low log2(BL) bits are (start + n) mod BL.
- R5: In interleaved order with burst length BL, beat n is the start column with its low log2(BL) bits XORed with n.
- R6: For a finite burst, col_last is 1 on beat BL-1 only, and col_valid is 0 in the cycle after that beat unless a new start was sampled.
- R7: A full-page burst steps all 10 column bits by +1 modulo 1024 on every clock, whatever the order bit says; col_last never rises, and the burst runs until a stop or a new start.
- R8: When stop_stb is sampled without start_stb, col_valid is 0 from the next cycle, at every burst length.
- R9: A start_stb sampled during a burst begins a new burst from the new start column; start_stb takes priority over a stop_stb in the same cycle.
- R10: A burst uses the length and order captured at its start; a mode-set during the burst changes only later bursts (cas_lat updates at once).
- R11: The unused length codes 100, 101 and 110 give a 1-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mrs_stb | input | 1 | Load mrs_op into the mode register |
| mrs_op | input | 7 | Mode opcode: length [2:0], order [3], CAS latency [6:4] |
| start_stb | input | 1 | Begin a burst at start_col |
| start_col | input | 10 | First column of the burst |
| stop_stb | input | 1 | End the running burst |
| col_addr | output | 10 | Column address of the current beat |
| col_valid | output | 1 | col_addr holds a beat |
| col_last | output | 1 | Current beat is the final beat of a finite burst |
| cas_lat | output | 3 | Stored CAS latency field |

## Verification
The bench builds the block with its default 10-bit column width, so full-page wrap across column 1023 can be reached within a few beats of a start near the top of the row. Every finite length is swept under both orders with start columns that cover aligned, misaligned, all-zero and all-one low bits, and each beat is compared with values computed arithmetically. All three unused length codes are checked for a single beat. Separate runs cover a stop in mid-burst, a restart that meets a stop in the same cycle, and a mode change during a burst.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst column sequencer.
// Assumes the opcode layout below is fixed; MODE_W follows from the struct.
package burst_seq_pkg;

    // Burst length codes held in the low opcode field.
    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } len_code_e;

    // Mode register image, MSB first: latency, order, length.
    typedef struct packed {
        logic [2:0] cas;
        logic       interleave;
        logic [2:0] len_code;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/bsq_mode_reg.sv
// Mode register for the burst sequencer.
// Stores the opcode on mrs_stb and decodes the length code into a low-bit
// mask (BL-1) and a full-page flag. Unused length codes decode as one beat.
// Assumes COL_W >= 3.
module bsq_mode_reg
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_stb,
    input  mode_t            mrs_op,
    output mode_t            mode_o,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o
);

    mode_t mode_q;

    // Hold the last programmed opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mrs_stb) begin
            mode_q <= mrs_op;
        end
    end

    // Decode the length code into a wrap mask.
    always_comb begin
        full_o = 1'b0;
        case (mode_q.len_code)
            LEN_2:    mask_o = COL_W'(1);
            LEN_4:    mask_o = COL_W'(3);
            LEN_8:    mask_o = COL_W'(7);
            LEN_PAGE: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default:  mask_o = '0;
        endcase
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/bsq_beat_ctr.sv
// Beat counter for the burst sequencer.
// Captures the burst shape at start, counts beats, and ends the burst on
// its final beat or on a stop. Start wins over stop. The count wraps
// naturally at 2**COL_W, which gives full-page wrap.
module bsq_beat_ctr #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_stb,
    input  logic             stop_stb,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    input  logic             il_i,
    output logic             act_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             il_o,
    output logic             last_o
);

    logic             act_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             il_q;

    // Final beat of a finite burst.
    assign last_o = act_q && !full_q && (cnt_q == mask_q);

    // Burst state: start, stop, step or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            cnt_q  <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            il_q   <= 1'b0;
        end else if (start_stb) begin
            act_q  <= 1'b1;
            cnt_q  <= '0;
            mask_q <= mask_i;
            full_q <= full_i;
            il_q   <= il_i;
        end else if (stop_stb) begin
            act_q  <= 1'b0;
        end else if (act_q) begin
            if (last_o) begin
                act_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign act_o  = act_q;
    assign cnt_o  = cnt_q;
    assign mask_o = mask_q;
    assign full_o = full_q;
    assign il_o   = il_q;

endmodule

// File: rtl/bsq_addr_gen.sv
// Column address generator for the burst sequencer.
// Keeps the start column and forms each beat's address from the beat
// count: add within the mask (sequential, full page) or XOR within the
// mask (interleaved). Full page always adds.
module bsq_addr_gen #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_stb,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    input  logic             il_i,
    output logic [COL_W-1:0] addr_o
);

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] seq_addr;
    logic [COL_W-1:0] xor_addr;

    // Capture the first column of each burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (start_stb) begin
            base_q <= start_col;
        end
    end

    // Both orderings, then pick one.
    always_comb begin
        seq_addr = (base_q & ~mask_i) | ((base_q + cnt_i) & mask_i);
        xor_addr = base_q ^ (cnt_i & mask_i);
        addr_o   = (il_i && !full_i) ? xor_addr : seq_addr;
    end

endmodule

// File: rtl/burst_col_seq.sv
// Burst column address sequencer (top).
// Holds the burst fields of the mode register and issues one column
// address per clock after a start strobe. Assumes the caller only starts
// bursts when the column stream may begin on the next cycle.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_stb,
    input  logic [MODE_W-1:0] mrs_op,
    input  logic             start_stb,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop_stb,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic [2:0]       cas_lat
);

    mode_t            mode;
    logic [COL_W-1:0] mode_mask;
    logic             mode_full;
    logic [COL_W-1:0] beat_cnt;
    logic [COL_W-1:0] burst_mask;
    logic             burst_full;
    logic             burst_il;

    bsq_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mrs_stb (mrs_stb),
        .mrs_op  (mode_t'(mrs_op)),
        .mode_o  (mode),
        .mask_o  (mode_mask),
        .full_o  (mode_full)
    );

    bsq_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_stb (start_stb),
        .stop_stb  (stop_stb),
        .mask_i    (mode_mask),
        .full_i    (mode_full),
        .il_i      (mode.interleave),
        .act_o     (col_valid),
        .cnt_o     (beat_cnt),
        .mask_o    (burst_mask),
        .full_o    (burst_full),
        .il_o      (burst_il),
        .last_o    (col_last)
    );

    bsq_addr_gen #(.COL_W(COL_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_stb (start_stb),
        .start_col (start_col),
        .cnt_i     (beat_cnt),
        .mask_i    (burst_mask),
        .full_i    (burst_full),
        .il_i      (burst_il),
        .addr_o    (col_addr)
    );

    assign cas_lat = mode.cas;

endmodule

// File: rtl/burst_col_seq_chk.sv
// Property checker for burst_col_seq, bound to every instance.
// Relates strobes to the column stream one cycle later.
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrs_stb,
    input logic [6:0]       mrs_op,
    input logic             start_stb,
    input logic [COL_W-1:0] start_col,
    input logic             stop_stb,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_last,
    input logic [2:0]       cas_lat,
    input logic             burst_full
);

    // R2: latency field visible after a mode-set
    a_r2_cas_load: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_stb |=> (cas_lat == $past(mrs_op[6:4])));

    // R3: first beat is the start column
    a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> (col_valid && col_addr == $past(start_col)));

    // R6: a finite burst ends after its last beat
    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_last && !start_stb) |=> !col_valid);

    // R6: last only flags a live beat
    a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R7: full page steps by one and never ends by itself
    a_r7_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && burst_full && !start_stb && !stop_stb) |=>
        (col_valid && !col_last && col_addr == COL_W'($past(col_addr) + 1'b1)));

    // R8: stop ends the burst
    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && !start_stb) |=> !col_valid);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mrs_stb    (mrs_stb),
    .mrs_op     (mrs_op),
    .start_stb  (start_stb),
    .start_col  (start_col),
    .stop_stb   (stop_stb),
    .col_addr   (col_addr),
    .col_valid  (col_valid),
    .col_last   (col_last),
    .cas_lat    (cas_lat),
    .burst_full (burst_full)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
// Self-checking sweep bench for burst_col_seq.
module test_burst_col_seq;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mrs_stb = 1'b0;
    logic [6:0]       mrs_op = '0;
    logic             start_stb = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             stop_stb = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_last;
    logic [2:0]       cas_lat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .mrs_op(mrs_op),
        .start_stb(start_stb), .start_col(start_col), .stop_stb(stop_stb),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
        .cas_lat(cas_lat)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 1024;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_addr(input int s, input int n, input int code, input int il);
        int bl = len_of(code);
        int m = bl - 1;
        if (code == 7) return (s + n) % 1024;
        if (il != 0) return s ^ (n & m);
        return (s & ~m & 1023) | ((s + n) & m);
    endfunction

    task automatic do_mrs(input int op, input string req);
        @(negedge clk);
        mrs_stb = 1'b1;
        mrs_op  = op[6:0];
        @(negedge clk);
        mrs_stb = 1'b0;
        check(req, int'(cas_lat), (op >> 4) & 7);
    endtask

    // Start a burst and check every beat plus the idle cycle after it.
    task automatic run_burst(input int s, input int code, input int il, input string req);
        int bl = len_of(code);
        @(negedge clk);
        start_stb = 1'b1;
        start_col = s[COL_W-1:0];
        @(negedge clk);
        start_stb = 1'b0;
        for (int n = 0; n < bl; n++) begin
            check({req, " valid"}, int'(col_valid), 1);
            check({req, " addr"}, int'(col_addr), exp_addr(s, n, code, il));
            check("R6 last", int'(col_last), (n == bl - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R6 idle after last", int'(col_valid), 0);
    endtask

    initial begin
        int starts[8] = '{0, 1023, 5, 683, 340, 7, 514, 1016};
        repeat (3) @(negedge clk);
        check("R1 valid", int'(col_valid), 0);
        check("R1 last", int'(col_last), 0);
        check("R1 cas", int'(cas_lat), 0);
        rst_n = 1'b1;
        // R1: reset mode gives a single beat at the start column
        run_burst(300, 0, 0, "R1 reset mode");

        // R2 R3 R4 R5 R6: all finite lengths, both orders
        for (int code = 0; code < 4; code++) begin
            for (int il = 0; il < 2; il++) begin
                do_mrs(((2 + il) << 4) | (il << 3) | code, "R2 cas");
                for (int k = 0; k < 8; k++)
                    run_burst(starts[k], code, il, il ? "R5 interleaved" : "R4 sequential");
            end
        end

        // R11: unused length codes give one beat
        for (int code = 4; code < 7; code++) begin
            do_mrs((3 << 4) | code, "R2 cas");
            run_burst(77, code, 0, "R11 reserved");
        end

        // R7 R8: full page with order bit set, wraps, then stopped
        do_mrs((3 << 4) | (1 << 3) | 7, "R2 cas");
        @(negedge clk);
        start_stb = 1'b1;
        start_col = 10'd1019;
        @(negedge clk);
        start_stb = 1'b0;
        for (int n = 0; n < 12; n++) begin
            check("R7 page valid", int'(col_valid), 1);
            check("R7 page addr", int'(col_addr), (1019 + n) % 1024);
            check("R7 page last", int'(col_last), 0);
            if (n == 11) stop_stb = 1'b1;
            @(negedge clk);
        end
        stop_stb = 1'b0;
        check("R8 page stop", int'(col_valid), 0);

        // R8: stop in the middle of an 8-beat burst
        do_mrs((2 << 4) | 3, "R2 cas");
        @(negedge clk);
        start_stb = 1'b1;
        start_col = 10'd41;
        @(negedge clk);
        start_stb = 1'b0;
        for (int n = 0; n < 3; n++) begin
            check("R8 pre-stop addr", int'(col_addr), exp_addr(41, n, 3, 0));
            if (n == 2) stop_stb = 1'b1;
            @(negedge clk);
        end
        stop_stb = 1'b0;
        check("R8 stop", int'(col_valid), 0);

        // R9: restart with stop in the same cycle, 4-beat sequential
        do_mrs((2 << 4) | 2, "R2 cas");
        @(negedge clk);
        start_stb = 1'b1;
        start_col = 10'd9;
        @(negedge clk);
        start_stb = 1'b0;
        check("R9 first burst", int'(col_addr), 9);
        start_stb = 1'b1;
        stop_stb  = 1'b1;
        start_col = 10'd22;
        @(negedge clk);
        start_stb = 1'b0;
        stop_stb  = 1'b0;
        for (int n = 0; n < 4; n++) begin
            check("R9 restart valid", int'(col_valid), 1);
            check("R9 restart addr", int'(col_addr), exp_addr(22, n, 2, 0));
            @(negedge clk);
        end
        check("R9 restart end", int'(col_valid), 0);

        // R10: mode-set during an 8-beat burst does not reshape it
        do_mrs((2 << 4) | 3, "R2 cas");
        @(negedge clk);
        start_stb = 1'b1;
        start_col = 10'd100;
        @(negedge clk);
        start_stb = 1'b0;
        for (int n = 0; n < 8; n++) begin
            check("R10 addr", int'(col_addr), exp_addr(100, n, 3, 0));
            check("R10 valid", int'(col_valid), 1);
            mrs_stb = (n == 1);
            mrs_op  = 7'((3 << 4) | (1 << 3) | 0);
            @(negedge clk);
        end
        mrs_stb = 1'b0;
        check("R10 end", int'(col_valid), 0);
        check("R10 cas updated", int'(cas_lat), 3);
        run_burst(100, 0, 1, "R10 new mode");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule